// File: doc/BRIEF.md
# Logical Lane to Pad Crossbar

This block sits between a small set of internal test peripherals and a large row of physical pads. It carries a fixed number of logical signal lanes, grouped into banks, and each lane can be steered to any pad through a programmable table held in the block. Any table entry that holds a value at or above the pad count, such as the all-ones code, leaves its lane unconnected.

Only one peripheral owns the lanes at a time, and the host picks it by writing a code. Only that peripheral can drive a lane's value and enable, and only on the lanes its function uses. All peripherals see the same synchronized lane inputs. The general-purpose mode has no external source. Its value and drive bits sit in host registers, one pair per lane. Two commands are available. The first clears everything, meaning the map, the selection and the GPIO state. The second clears only the peripherals and keeps the map.

The host reaches the block through a simple single-cycle register port. Writes take effect at the clock edge and reads are combinational. The layout is: map entries at addresses 0 to L-1 (L = lane count), owner code at L, command at L+1, GPIO value per bank at L+2 upwards, GPIO drive per bank after those, and synchronized lane inputs per bank after those. Bank b holds lanes b*W to b*W+W-1 in bits 0 to W-1. With the default configuration these addresses are 0x00-0x0F, 0x10, 0x11, 0x12-0x13, 0x14-0x15 and 0x16-0x17.

Top module: `lane_pad_xbar`

## Requirements
- R1: While reset is low and after it is released, every map entry reads 0xFF, the owner code reads 0, no pad is enabled and the peripheral clear output is high.
- R2: A map entry written with pad index p (p below the pad count) routes its lane to pad p and reads back as written. An entry at or above the pad count, including 0xFF, drives no pad.
- R3: Only the peripheral named by the owner code drives pads. With code 1 (GPIO), a lane's pad takes the lane's value bit while its drive bit is 1 and is not enabled while the drive bit is 0.
- R4: Each owner code has a lane mask that applies within every bank. SPI controller (code 2), UART (code 4) and SPI target (code 6) may enable only bank lanes 0 to 3. I2C (code 5) may enable only bank lanes 0 and 1. GPIO may enable all lanes.
- R5: Any other owner code, including 0, forces every pad enable low whatever the peripherals present.
- R6: When several lanes map to the same pad, the lowest-numbered lane owns it, and the pad's value and enable come from that lane even when its enable is low.
- R7: A pad's output value is 0 whenever its enable is low.
- R8: Each pad input passes through two flops before it reaches the lane that maps to it. A lane with no valid pad reads 0. Lane inputs can be read both on the lane output port and at the lane input registers.
- R9: Writing the command register with bit 0 set clears every map entry to 0xFF, the owner code to 0 and the GPIO bits, and raises the peripheral clear for one cycle.
- R10: Writing the command register with bit 1 set (bit 0 clear) clears the GPIO bits and raises the peripheral clear for the next cycle, and leaves the map and the owner code unchanged.
- R11: Once reset is released, the peripheral clear output is high only in the cycle after a command write with bit 0 or bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| spim_o | input | N_LANES | SPI controller lane values |
| spim_oe | input | N_LANES | SPI controller lane enables |
| uart_o | input | N_LANES | UART lane values |
| uart_oe | input | N_LANES | UART lane enables |
| i2c_o | input | N_LANES | I2C lane values |
| i2c_oe | input | N_LANES | I2C lane enables |
| spit_o | input | N_LANES | SPI target lane values |
| spit_oe | input | N_LANES | SPI target lane enables |
| lane_in | output | N_LANES | Synchronized lane inputs, shared by all peripherals |
| periph_clr | output | 1 | One-cycle clear pulse to the peripherals |
| pad_i | input | N_PADS | Pad input samples |
| pad_o | output | N_PADS | Pad output values |
| pad_oe | output | N_PADS | Pad output enables |

## Verification
The bench uses the default build: two banks of eight lanes and 128 pads. With this build the top pad index 127 is reachable, and so is the first index past the end (128). Both routed lanes and dead lanes can be checked against the full 128-bit enable vector. Lanes in both banks, including lane 9 in bank 1, show that the per-bank masks repeat. With every peripheral's enables held high, each owner code and the masking of its unused lanes can be seen at the pads.

// File: rtl/lpx_pkg.sv
// Package: codes and constants shared by the lane crossbar modules.
// Assumes map entries and register data are one byte wide.
package lpx_pkg;
    localparam int          DATA_W   = 8;
    localparam logic [7:0]  PAD_NC   = 8'hFF;

    // Owner codes written by the host.
    localparam logic [7:0]  OWN_GPIO = 8'd1;
    localparam logic [7:0]  OWN_SPIM = 8'd2;
    localparam logic [7:0]  OWN_UART = 8'd4;
    localparam logic [7:0]  OWN_I2C  = 8'd5;
    localparam logic [7:0]  OWN_SPIT = 8'd6;

    // Per-bank lane masks for the serial peripherals.
    localparam logic [7:0]  MASK_QUAD = 8'h0F;
    localparam logic [7:0]  MASK_PAIR = 8'h03;

    // Command register bits.
    localparam int          CMD_FULL  = 0;
    localparam int          CMD_PERIPH = 1;
endpackage

// File: rtl/lpx_regs.sv
// Module: host register file of the lane crossbar.
// Holds the lane-to-pad map, the owner code and the GPIO value/drive bits.
// Decodes the two clear commands and produces the peripheral clear pulse.
// Assumes BANK_W <= 8 and single-cycle writes; reads are combinational.
module lpx_regs
    import lpx_pkg::*;
#(
    parameter int N_BANKS = 2,
    parameter int BANK_W  = 8,
    parameter int ADDR_W  = 5,
    localparam int N_LANES = N_BANKS * BANK_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [DATA_W-1:0]               reg_wdata,
    output logic [DATA_W-1:0]               reg_rdata,
    input  logic [N_LANES-1:0]              lane_in,
    output logic [N_LANES-1:0][DATA_W-1:0]  map_q,
    output logic [DATA_W-1:0]               sel_q,
    output logic [N_LANES-1:0]              gpio_val_q,
    output logic [N_LANES-1:0]              gpio_drv_q,
    output logic                            periph_clr
);
    localparam int A_SEL  = N_LANES;
    localparam int A_CMD  = N_LANES + 1;
    localparam int A_GVAL = N_LANES + 2;
    localparam int A_GDRV = A_GVAL + N_BANKS;
    localparam int A_LIN  = A_GDRV + N_BANKS;

    logic cmd_wr;
    logic full_clr;
    logic part_clr;

    // Command decode for the two clear operations.
    assign cmd_wr   = reg_wr && (int'(reg_addr) == A_CMD);
    assign full_clr = cmd_wr && reg_wdata[CMD_FULL];
    assign part_clr = cmd_wr && reg_wdata[CMD_PERIPH];

    // Map table: cleared to not-connected on reset or full clear.
    always_ff @(posedge clk) begin
        if (!rst_n || full_clr) begin
            for (int l = 0; l < N_LANES; l++) map_q[l] <= PAD_NC;
        end else if (reg_wr) begin
            for (int l = 0; l < N_LANES; l++)
                if (int'(reg_addr) == l) map_q[l] <= reg_wdata;
        end
    end

    // Owner code register.
    always_ff @(posedge clk) begin
        if (!rst_n || full_clr)                       sel_q <= '0;
        else if (reg_wr && int'(reg_addr) == A_SEL)   sel_q <= reg_wdata;
    end

    // GPIO value and drive bits, cleared by either command.
    always_ff @(posedge clk) begin
        if (!rst_n || full_clr || part_clr) begin
            gpio_val_q <= '0;
            gpio_drv_q <= '0;
        end else if (reg_wr) begin
            for (int b = 0; b < N_BANKS; b++) begin
                if (int'(reg_addr) == A_GVAL + b)
                    gpio_val_q[b*BANK_W +: BANK_W] <= reg_wdata[BANK_W-1:0];
                if (int'(reg_addr) == A_GDRV + b)
                    gpio_drv_q[b*BANK_W +: BANK_W] <= reg_wdata[BANK_W-1:0];
            end
        end
    end

    // Peripheral clear pulse: high during reset and for one cycle after a command.
    always_ff @(posedge clk) begin
        periph_clr <= !rst_n || full_clr || part_clr;
    end

    // Combinational read mux.
    always_comb begin
        reg_rdata = '0;
        for (int l = 0; l < N_LANES; l++)
            if (int'(reg_addr) == l) reg_rdata = map_q[l];
        if (int'(reg_addr) == A_SEL) reg_rdata = sel_q;
        for (int b = 0; b < N_BANKS; b++) begin
            if (int'(reg_addr) == A_GVAL + b)
                reg_rdata = DATA_W'(gpio_val_q[b*BANK_W +: BANK_W]);
            if (int'(reg_addr) == A_GDRV + b)
                reg_rdata = DATA_W'(gpio_drv_q[b*BANK_W +: BANK_W]);
            if (int'(reg_addr) == A_LIN + b)
                reg_rdata = DATA_W'(lane_in[b*BANK_W +: BANK_W]);
        end
    end
endmodule

// File: rtl/lpx_owner.sv
// Module: lane ownership selector.
// Chooses the value/enable vectors of the peripheral named by the owner code,
// applies that peripheral's per-bank lane mask, and forces all enables low for
// an unused code. Lane values are zeroed where the enable is low.
// Assumes BANK_W <= 8.
module lpx_owner
    import lpx_pkg::*;
#(
    parameter int N_BANKS = 2,
    parameter int BANK_W  = 8,
    localparam int N_LANES = N_BANKS * BANK_W
) (
    input  logic [DATA_W-1:0]   sel_q,
    input  logic [N_LANES-1:0]  gpio_val_q,
    input  logic [N_LANES-1:0]  gpio_drv_q,
    input  logic [N_LANES-1:0]  spim_o,
    input  logic [N_LANES-1:0]  spim_oe,
    input  logic [N_LANES-1:0]  uart_o,
    input  logic [N_LANES-1:0]  uart_oe,
    input  logic [N_LANES-1:0]  i2c_o,
    input  logic [N_LANES-1:0]  i2c_oe,
    input  logic [N_LANES-1:0]  spit_o,
    input  logic [N_LANES-1:0]  spit_oe,
    output logic [N_LANES-1:0]  lane_o,
    output logic [N_LANES-1:0]  lane_oe
);
    logic [BANK_W-1:0]  bank_mask;
    logic [N_LANES-1:0] src_o;
    logic [N_LANES-1:0] src_oe;

    // Source and mask selection by owner code.
    always_comb begin
        bank_mask = '0;
        src_o     = '0;
        src_oe    = '0;
        case (sel_q)
            OWN_GPIO: begin src_o = gpio_val_q; src_oe = gpio_drv_q; bank_mask = '1; end
            OWN_SPIM: begin src_o = spim_o; src_oe = spim_oe; bank_mask = MASK_QUAD[BANK_W-1:0]; end
            OWN_UART: begin src_o = uart_o; src_oe = uart_oe; bank_mask = MASK_QUAD[BANK_W-1:0]; end
            OWN_I2C:  begin src_o = i2c_o;  src_oe = i2c_oe;  bank_mask = MASK_PAIR[BANK_W-1:0]; end
            OWN_SPIT: begin src_o = spit_o; src_oe = spit_oe; bank_mask = MASK_QUAD[BANK_W-1:0]; end
            default:  begin bank_mask = '0; end
        endcase
    end

    // Mask repeated across banks; value gated by enable.
    always_comb begin
        lane_oe = src_oe & {N_BANKS{bank_mask}};
        lane_o  = src_o & lane_oe;
    end
endmodule

// File: rtl/lpx_pad_route.sv
// Module: pad routing fabric.
// Each pad takes the value and enable of the lowest-numbered lane mapped to it.
// Pads with no mapped lane stay disabled. Pad inputs go through a two-flop
// synchronizer, and each lane then picks the synchronized input of its pad.
// Assumes N_PADS <= 255 so that 0xFF never names a pad.
module lpx_pad_route
    import lpx_pkg::*;
#(
    parameter int N_LANES = 16,
    parameter int N_PADS  = 128,
    localparam int PIDX_W = (N_PADS > 1) ? $clog2(N_PADS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_LANES-1:0][DATA_W-1:0]  map_q,
    input  logic [N_LANES-1:0]              lane_o,
    input  logic [N_LANES-1:0]              lane_oe,
    input  logic [N_PADS-1:0]               pad_i,
    output logic [N_PADS-1:0]               pad_o,
    output logic [N_PADS-1:0]               pad_oe,
    output logic [N_LANES-1:0]              lane_in
);
    logic [N_PADS-1:0] sync1_q;
    logic [N_PADS-1:0] sync2_q;

    // Two-stage input synchronizer on every pad.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pad_i;
            sync2_q <= sync1_q;
        end
    end

    // Per-pad driver pick, lowest lane wins.
    for (genvar p = 0; p < N_PADS; p++) begin : g_pad
        logic drv_o;
        logic drv_oe;
        always_comb begin
            drv_o  = 1'b0;
            drv_oe = 1'b0;
            for (int l = N_LANES - 1; l >= 0; l--) begin
                if (int'(map_q[l]) == p) begin
                    drv_o  = lane_o[l];
                    drv_oe = lane_oe[l];
                end
            end
            pad_oe[p] = drv_oe;
            pad_o[p]  = drv_o & drv_oe;
        end
    end

    // Lane input gather from synchronized pads.
    always_comb begin
        for (int l = 0; l < N_LANES; l++) begin
            if (int'(map_q[l]) < N_PADS) lane_in[l] = sync2_q[map_q[l][PIDX_W-1:0]];
            else                         lane_in[l] = 1'b0;
        end
    end
endmodule

// File: rtl/lane_pad_xbar.sv
// Module: top of the logical-lane to pad crossbar.
// Connects the register file, the ownership selector and the pad routing.
// Assumes a single clock and a synchronous active-low reset.
module lane_pad_xbar
    import lpx_pkg::*;
#(
    parameter int N_BANKS = 2,
    parameter int BANK_W  = 8,
    parameter int N_PADS  = 128,
    localparam int N_LANES = N_BANKS * BANK_W,
    localparam int ADDR_W  = $clog2(N_LANES + 2 + 3 * N_BANKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [N_LANES-1:0]  spim_o,
    input  logic [N_LANES-1:0]  spim_oe,
    input  logic [N_LANES-1:0]  uart_o,
    input  logic [N_LANES-1:0]  uart_oe,
    input  logic [N_LANES-1:0]  i2c_o,
    input  logic [N_LANES-1:0]  i2c_oe,
    input  logic [N_LANES-1:0]  spit_o,
    input  logic [N_LANES-1:0]  spit_oe,
    output logic [N_LANES-1:0]  lane_in,
    output logic                periph_clr,
    input  logic [N_PADS-1:0]   pad_i,
    output logic [N_PADS-1:0]   pad_o,
    output logic [N_PADS-1:0]   pad_oe
);
    logic [N_LANES-1:0][DATA_W-1:0] map_q;
    logic [DATA_W-1:0]              sel_q;
    logic [N_LANES-1:0]             gpio_val_q;
    logic [N_LANES-1:0]             gpio_drv_q;
    logic [N_LANES-1:0]             lane_o;
    logic [N_LANES-1:0]             lane_oe;

    lpx_regs #(.N_BANKS(N_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .lane_in    (lane_in),
        .map_q      (map_q),
        .sel_q      (sel_q),
        .gpio_val_q (gpio_val_q),
        .gpio_drv_q (gpio_drv_q),
        .periph_clr (periph_clr)
    );

    lpx_owner #(.N_BANKS(N_BANKS), .BANK_W(BANK_W)) owner_i (
        .sel_q      (sel_q),
        .gpio_val_q (gpio_val_q),
        .gpio_drv_q (gpio_drv_q),
        .spim_o     (spim_o),
        .spim_oe    (spim_oe),
        .uart_o     (uart_o),
        .uart_oe    (uart_oe),
        .i2c_o      (i2c_o),
        .i2c_oe     (i2c_oe),
        .spit_o     (spit_o),
        .spit_oe    (spit_oe),
        .lane_o     (lane_o),
        .lane_oe    (lane_oe)
    );

    lpx_pad_route #(.N_LANES(N_LANES), .N_PADS(N_PADS)) route_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .map_q   (map_q),
        .lane_o  (lane_o),
        .lane_oe (lane_oe),
        .pad_i   (pad_i),
        .pad_o   (pad_o),
        .pad_oe  (pad_oe),
        .lane_in (lane_in)
    );
endmodule

// File: rtl/lpx_chk.sv
// Module: assertion checker for lane_pad_xbar, attached by bind below.
// Observes the register port, the owner code, the map and the pad outputs.
module lpx_chk
    import lpx_pkg::*;
#(
    parameter int N_BANKS = 2,
    parameter int BANK_W  = 8,
    parameter int N_PADS  = 128,
    localparam int N_LANES = N_BANKS * BANK_W,
    localparam int ADDR_W  = $clog2(N_LANES + 2 + 3 * N_BANKS),
    localparam int A_CMD   = N_LANES + 1
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            reg_wr,
    input logic [ADDR_W-1:0]               reg_addr,
    input logic [1:0]                      cmd_bits,
    input logic [DATA_W-1:0]               sel_q,
    input logic [N_LANES-1:0][DATA_W-1:0]  map_q,
    input logic [N_LANES-1:0]              lane_in,
    input logic [N_PADS-1:0]               pad_o,
    input logic [N_PADS-1:0]               pad_oe,
    input logic                            periph_clr
);
    logic cmd_any;
    logic cmd_full;
    logic cmd_part_only;
    logic sel_used;

    assign cmd_any       = reg_wr && (int'(reg_addr) == A_CMD) && (cmd_bits != 2'b00);
    assign cmd_full      = reg_wr && (int'(reg_addr) == A_CMD) && cmd_bits[0];
    assign cmd_part_only = reg_wr && (int'(reg_addr) == A_CMD) && (cmd_bits == 2'b10);
    assign sel_used      = (sel_q == OWN_GPIO) || (sel_q == OWN_SPIM) || (sel_q == OWN_UART)
                        || (sel_q == OWN_I2C)  || (sel_q == OWN_SPIT);

    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_o & ~pad_oe) == '0);

    a_r5_unused_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_used |-> pad_oe == '0);

    a_r4_i2c_pair_only: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == OWN_I2C) |-> $countones(pad_oe) <= 2 * N_BANKS);

    a_r9_full_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_full |=> (pad_oe == '0 && sel_q == '0));

    a_r10_map_kept: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_part_only |=> ($stable(map_q) && $stable(sel_q) && periph_clr));

    a_r11_clr_only_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !cmd_any) |=> !periph_clr);

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        a_r8_dead_lane_low: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(map_q[l]) >= N_PADS) |-> !lane_in[l]);
    end
endmodule

bind lane_pad_xbar lpx_chk #(.N_BANKS(N_BANKS), .BANK_W(BANK_W), .N_PADS(N_PADS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .cmd_bits   (reg_wdata[1:0]),
    .sel_q      (sel_q),
    .map_q      (map_q),
    .lane_in    (lane_in),
    .pad_o      (pad_o),
    .pad_oe     (pad_oe),
    .periph_clr (periph_clr)
);

// File: tb/lane_pad_xbar_tb_top.sv
// Directed bench for lane_pad_xbar with default parameters.
module lane_pad_xbar_tb_top;
    localparam int N_BANKS = 2;
    localparam int BANK_W  = 8;
    localparam int N_PADS  = 128;
    localparam int N_LANES = N_BANKS * BANK_W;
    localparam int ADDR_W  = 5;
    localparam int A_SEL   = N_LANES;
    localparam int A_CMD   = N_LANES + 1;
    localparam int A_GVAL  = N_LANES + 2;
    localparam int A_GDRV  = A_GVAL + N_BANKS;
    localparam int A_LIN   = A_GDRV + N_BANKS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [N_LANES-1:0] spim_o = '0, spim_oe = '0, uart_o = '0, uart_oe = '0;
    logic [N_LANES-1:0] i2c_o = '0, i2c_oe = '0, spit_o = '0, spit_oe = '0;
    logic [N_LANES-1:0] lane_in;
    logic periph_clr;
    logic [N_PADS-1:0] pad_i = '0;
    logic [N_PADS-1:0] pad_o;
    logic [N_PADS-1:0] pad_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lane_pad_xbar #(.N_BANKS(N_BANKS), .BANK_W(BANK_W), .N_PADS(N_PADS)) dut_i (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .spim_o, .spim_oe, .uart_o, .uart_oe, .i2c_o, .i2c_oe, .spit_o, .spit_oe,
        .lane_in, .periph_clr, .pad_i, .pad_o, .pad_oe
    );

    task automatic chk(input string tag, input logic [N_PADS-1:0] act, input logic [N_PADS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        reg_addr = ADDR_W'(a);
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [N_PADS-1:0] bit_at(input int p);
        logic [N_PADS-1:0] v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 clear high in reset", N_PADS'(periph_clr), 1);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd(0, d);  chk("R1 map lane0 NC", N_PADS'(d), 8'hFF);
        rd(15, d); chk("R1 map lane15 NC", N_PADS'(d), 8'hFF);
        rd(A_SEL, d); chk("R1 owner 0", N_PADS'(d), 0);
        chk("R1 no pad enabled", pad_oe, '0);
    endtask

    task automatic t_gpio();
        logic [7:0] d;
        wr(0, 8'd5); wr(9, 8'd127);
        wr(A_SEL, 8'd1);
        wr(A_GVAL, 8'h01); wr(A_GDRV, 8'h01);
        wr(A_GVAL + 1, 8'h02); wr(A_GDRV + 1, 8'h02);
        chk("R3 gpio enables pads 5,127", pad_oe, bit_at(5) | bit_at(127));
        chk("R2 gpio values pads 5,127", pad_o, bit_at(5) | bit_at(127));
        rd(9, d); chk("R2 map readback 127", N_PADS'(d), 127);
        wr(A_GDRV, 8'h00);
        chk("R3 drive clear releases pad 5", pad_oe, bit_at(127));
        chk("R7 pad 5 value zero", N_PADS'(pad_o[5]), 0);
    endtask

    task automatic t_range();
        wr(1, 8'd128);
        wr(A_GVAL, 8'h02); wr(A_GDRV, 8'h02);
        chk("R2 index 128 drives nothing", pad_oe, bit_at(127));
        wr(1, 8'hFF);
        chk("R2 index FF drives nothing", pad_oe, bit_at(127));
    endtask

    task automatic t_owner();
        spim_o = '1; spim_oe = '1; uart_o = '1; uart_oe = '1;
        i2c_o = '1; i2c_oe = '1; spit_o = '1; spit_oe = '1;
        wr(4, 8'd20); wr(2, 8'd21); wr(1, 8'd22);
        wr(A_SEL, 8'd2);
        chk("R4 spi ctrl lanes 0-3 only", pad_oe, bit_at(5) | bit_at(21) | bit_at(22) | bit_at(127));
        wr(A_SEL, 8'd5);
        chk("R4 i2c lanes 0-1 only", pad_oe, bit_at(5) | bit_at(22) | bit_at(127));
        wr(A_SEL, 8'd4);
        chk("R4 uart lanes 0-3 only", pad_oe, bit_at(5) | bit_at(21) | bit_at(22) | bit_at(127));
        uart_oe = '0;
        #1;
        chk("R3 uart enables followed", pad_oe, '0);
        wr(A_SEL, 8'd6);
        chk("R4 spi target lanes 0-3", pad_oe, bit_at(5) | bit_at(21) | bit_at(22) | bit_at(127));
        wr(A_SEL, 8'd3);
        chk("R5 code 3 silent", pad_oe, '0);
        wr(A_SEL, 8'd0);
        chk("R5 code 0 silent", pad_oe, '0);
        chk("R7 no value while silent", pad_o, '0);
        spim_oe = '0; uart_oe = '0; i2c_oe = '0; spit_oe = '0;
    endtask

    task automatic t_priority();
        wr(A_SEL, 8'd1);
        wr(3, 8'd40); wr(6, 8'd40);
        wr(A_GVAL, 8'h40); wr(A_GDRV, 8'h48);
        chk("R6 lower lane wins oe", N_PADS'(pad_oe[40]), 1);
        chk("R6 lower lane wins value", N_PADS'(pad_o[40]), 0);
        wr(A_GDRV, 8'h40);
        chk("R6 lower lane owns when off", N_PADS'(pad_oe[40]), 0);
    endtask

    task automatic t_input();
        logic [7:0] d;
        wr(10, 8'd60);
        @(negedge clk); pad_i[60] = 1'b1; pad_i[61] = 1'b1;
        @(negedge clk); #1;
        chk("R8 one flop not yet", N_PADS'(lane_in[10]), 0);
        @(negedge clk); #1;
        chk("R8 after two flops", N_PADS'(lane_in[10]), 1);
        chk("R8 unmapped lane 11 low", N_PADS'(lane_in[11]), 0);
        rd(A_LIN + 1, d); chk("R8 lane input register", N_PADS'(d), 8'h04);
    endtask

    task automatic t_preset();
        logic [7:0] d;
        wr(A_GVAL + 1, 8'hFF);
        wr(A_CMD, 8'h02);
        chk("R10 clear pulse", N_PADS'(periph_clr), 1);
        @(negedge clk); #1;
        chk("R11 pulse one cycle", N_PADS'(periph_clr), 0);
        rd(A_GVAL + 1, d); chk("R10 gpio cleared", N_PADS'(d), 0);
        rd(10, d); chk("R10 map kept", N_PADS'(d), 60);
        rd(A_SEL, d); chk("R10 owner kept", N_PADS'(d), 1);
    endtask

    task automatic t_full();
        logic [7:0] d;
        wr(A_GDRV + 1, 8'h02);
        chk("R9 pre pad 127 on", pad_oe, bit_at(127));
        wr(A_CMD, 8'h01);
        chk("R9 clear pulse", N_PADS'(periph_clr), 1);
        chk("R9 pads released", pad_oe, '0);
        rd(9, d); chk("R9 map NC", N_PADS'(d), 8'hFF);
        rd(A_SEL, d); chk("R9 owner 0", N_PADS'(d), 0);
        rd(A_GDRV + 1, d); chk("R9 drive cleared", N_PADS'(d), 0);
        rd(A_LIN + 1, d); chk("R9 R8 lane inputs dead", N_PADS'(d), 0);
    endtask

    initial begin
        t_reset();
        t_gpio();
        t_range();
        t_owner();
        t_priority();
        t_input();
        t_preset();
        t_full();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule